// File: doc/BRIEF.md
# Output Voltage Target Selector with Rising-Edge Slew Limiting

This block feeds the reference DAC of a step-down regulator. Two register sets each hold a 6-bit voltage code, a forced-PWM bit and a software enable. An external select pin chooses one set. The chosen set is registered as the target, and its mode bit and enable go straight out as registered flags.

An internal reference code then tracks the target. When the target is above the reference, the code climbs one LSB per step interval. The interval is `BASE_TICKS` system ticks at slew code 0 and doubles with each higher slew code. The code scale is 0.60 V plus 12.5 mV per LSB, so code 0 gives the fastest ramp (80 mV/µs) and code 7 the slowest (0.625 mV/µs) once `BASE_TICKS` is matched to the tick period.

When the target is below the reference, the code drops to it in one clock. A switching-inhibit flag then holds until an external comparator reports that the output has come down to the new set point.

Top module: `vref_slew_ctl`

## Requirements
- R1: With `sel_i` = 0 the set-0 inputs (`s0_*`) are selected; with `sel_i` = 1 the set-1 inputs (`s1_*`) are selected. The selected enable appears on `sw_en_o` one clock after the inputs, and the selected code becomes the target in that same clock.
- R2: `force_pwm_o` follows the selected mode bit one clock after the inputs. A value of 1 means forced PWM; a value of 0 means automatic light-load PFM is allowed.
- R3: While the target exceeds `ref_code_o`, the code rises by exactly 1 after every N cycles in which `tick_i` is high, where N = `BASE_TICKS` * 2^`slew_i` (`slew_i` = 0 is the fastest, 7 the slowest). Cycles with `tick_i` low do not count toward N.
- R4: When the target is below `ref_code_o`, the code equals the target on the next clock.
- R5: A downward jump sets `sw_inhibit_o` in the same clock as the jump. The flag stays high until a later clock samples `at_setpoint_i` = 1. At any other time `at_setpoint_i` has no effect.
- R6: If the target changes mid-ramp, the ramp continues from the present code. A new target above the code keeps stepping; a new target below the code takes the R4 jump at once.
- R7: `ramp_done_o` is 1 exactly when `ref_code_o` equals the registered target.
- R8: A synchronous reset sets the code and target to `RESET_CODE`, clears `force_pwm_o`, `sw_en_o` and `sw_inhibit_o`, restarts the step count, and so leaves `ramp_done_o` high.
- R9: A rising ramp never passes the target, and it never moves by more than one LSB in a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register-set select pin |
| s0_code_i | input | 6 | Set 0 voltage code |
| s0_pwm_i | input | 1 | Set 0 forced-PWM bit |
| s0_en_i | input | 1 | Set 0 software enable |
| s1_code_i | input | 6 | Set 1 voltage code |
| s1_pwm_i | input | 1 | Set 1 forced-PWM bit |
| s1_en_i | input | 1 | Set 1 software enable |
| slew_i | input | 3 | Rising slew code (0 fastest) |
| tick_i | input | 1 | Timebase tick for step counting |
| at_setpoint_i | input | 1 | Comparator: output has reached set point |
| ref_code_o | output | 6 | Reference code to the DAC |
| force_pwm_o | output | 1 | Forced-PWM flag of the selected set |
| sw_en_o | output | 1 | Software enable of the selected set |
| sw_inhibit_o | output | 1 | Switching inhibit after a downward jump |
| ramp_done_o | output | 1 | Reference equals target |

## Verification
The bench builds the block with `BASE_TICKS` = 2 and `RESET_CODE` = 20. With these values even slew code 7 has a 256-tick interval, so every slew code, including the slowest, finishes real steps within a short run. The non-zero reset code lets both a first rise and a first fall start straight from reset.

The tick input is driven every cycle and, in other phases, only every third cycle. This shows that idle cycles do not count toward the step interval. Retargets arrive mid-ramp in both directions, and comparator pulses arrive both while the inhibit is up and while it is down.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  parameter int CODE_W = 6;

  typedef struct packed {
    logic              en;
    logic              pwm;
    logic [CODE_W-1:0] code;
  } vset_t;
endpackage

// File: rtl/vsel_target_mux.sv
module vsel_target_mux #(
  parameter int RESET_CODE = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_i,
  input  vsel_pkg::vset_t set0_i,
  input  vsel_pkg::vset_t set1_i,
  output vsel_pkg::vset_t tgt_o
);
  import vsel_pkg::*;

  vset_t choice;
  vset_t tgt_q;

  always_comb begin
    choice = sel_i ? set1_i : set0_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q.en   <= 1'b0;
      tgt_q.pwm  <= 1'b0;
      tgt_q.code <= CODE_W'(RESET_CODE);
    end else begin
      tgt_q <= choice;
    end
  end

  assign tgt_o = tgt_q;

  // R1
  sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tgt_q == (($past(sel_i)) ? $past(set1_i) : $past(set0_i))));
endmodule

// File: rtl/vsel_step_timer.sv
module vsel_step_timer #(
  parameter int BASE_TICKS = 4,
  parameter int SLEW_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [SLEW_W-1:0] slew_i,
  output logic              fire_o
);
  localparam int MAX_IV = BASE_TICKS << ((1 << SLEW_W) - 1);
  localparam int CNT_W  = $clog2(MAX_IV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'((BASE_TICKS << slew_i) - 1);
  assign fire_o   = run_i && tick_i && (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (fire_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: an idle tick leaves the count unchanged
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> (cnt_q == $past(cnt_q) || !$past(run_i) || !run_i || cnt_q == '0));

  // R3: a step restarts the count
  fire_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/vsel_ref_tracker.sv
module vsel_ref_tracker #(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] tgt_i,
  input  logic              fire_i,
  input  logic              at_sp_i,
  output logic              run_o,
  output logic [CODE_W-1:0] ref_o,
  output logic              inhibit_o,
  output logic              done_o
);
  logic [CODE_W-1:0] ref_q;
  logic              inh_q;
  logic              drop;

  assign drop  = tgt_i < ref_q;
  assign run_o = tgt_i > ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= CODE_W'(RESET_CODE);
      inh_q <= 1'b0;
    end else if (drop) begin
      ref_q <= tgt_i;
      inh_q <= 1'b1;
    end else begin
      if (fire_i && run_o) ref_q <= ref_q + 1'b1;
      if (at_sp_i)         inh_q <= 1'b0;
    end
  end

  assign ref_o     = ref_q;
  assign inhibit_o = inh_q;
  assign done_o    = (ref_q == tgt_i);

  // R4
  drop_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_i < ref_q) |=> (ref_q == $past(tgt_i)));

  // R5
  inhibit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_i < ref_q) |=> inh_q);

  // R5
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inh_q && !at_sp_i) |=> inh_q);

  // R9
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_q > $past(ref_q)) |-> (ref_q == $past(ref_q) + 1'b1 && ref_q <= $past(tgt_i)));
endmodule

// File: rtl/vref_slew_ctl.sv
module vref_slew_ctl #(
  parameter int BASE_TICKS = 4,
  parameter int SLEW_W     = 3,
  parameter int RESET_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic [5:0]        s0_code_i,
  input  logic              s0_pwm_i,
  input  logic              s0_en_i,
  input  logic [5:0]        s1_code_i,
  input  logic              s1_pwm_i,
  input  logic              s1_en_i,
  input  logic [SLEW_W-1:0] slew_i,
  input  logic              tick_i,
  input  logic              at_setpoint_i,
  output logic [5:0]        ref_code_o,
  output logic              force_pwm_o,
  output logic              sw_en_o,
  output logic              sw_inhibit_o,
  output logic              ramp_done_o
);
  import vsel_pkg::*;

  vset_t set0, set1, tgt;
  logic  run, fire;

  assign set0 = '{en: s0_en_i, pwm: s0_pwm_i, code: s0_code_i};
  assign set1 = '{en: s1_en_i, pwm: s1_pwm_i, code: s1_code_i};

  vsel_target_mux #(.RESET_CODE(RESET_CODE)) u_mux (
    .clk(clk), .rst(rst), .sel_i(sel_i),
    .set0_i(set0), .set1_i(set1), .tgt_o(tgt)
  );

  vsel_step_timer #(.BASE_TICKS(BASE_TICKS), .SLEW_W(SLEW_W)) u_tmr (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(tick_i),
    .slew_i(slew_i), .fire_o(fire)
  );

  vsel_ref_tracker #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_trk (
    .clk(clk), .rst(rst), .tgt_i(tgt.code), .fire_i(fire),
    .at_sp_i(at_setpoint_i), .run_o(run), .ref_o(ref_code_o),
    .inhibit_o(sw_inhibit_o), .done_o(ramp_done_o)
  );

  assign force_pwm_o = tgt.pwm;
  assign sw_en_o     = tgt.en;

  // R2
  pwm_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (force_pwm_o == ($past(sel_i) ? $past(s1_pwm_i) : $past(s0_pwm_i))));
endmodule

// File: tb/sim_vref_slew_ctl.sv
module sim_vref_slew_ctl;
  localparam int BT = 2;
  localparam int RC = 20;

  logic clk = 0, rst = 1;
  logic sel = 0, p0 = 0, e0 = 0, p1 = 0, e1 = 0, tick = 0, atsp = 0;
  logic [5:0] c0 = 6'(RC), c1 = 6'(RC);
  logic [2:0] slew = 0;
  logic [5:0] ref_code;
  logic pwm_o, en_o, inh_o, done_o;

  int errors = 0, checks = 0, tick_div = 1, cyc = 0;
  bit started = 0;

  // behavioural reference state
  int m_ref = RC, m_tgt = RC, m_cnt = 0;
  bit m_pwm = 0, m_en = 0, m_inh = 0;

  always #5 clk = ~clk;

  vref_slew_ctl #(.BASE_TICKS(BT), .SLEW_W(3), .RESET_CODE(RC)) u0 (
    .clk(clk), .rst(rst), .sel_i(sel),
    .s0_code_i(c0), .s0_pwm_i(p0), .s0_en_i(e0),
    .s1_code_i(c1), .s1_pwm_i(p1), .s1_en_i(e1),
    .slew_i(slew), .tick_i(tick), .at_setpoint_i(atsp),
    .ref_code_o(ref_code), .force_pwm_o(pwm_o), .sw_en_o(en_o),
    .sw_inhibit_o(inh_o), .ramp_done_o(done_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ref = RC; m_tgt = RC; m_cnt = 0; m_pwm = 0; m_en = 0; m_inh = 0;
    end else begin
      if (m_tgt < m_ref) begin
        m_ref = m_tgt; m_inh = 1; m_cnt = 0;
      end else begin
        if (m_tgt > m_ref) begin
          if (tick) begin
            if (m_cnt >= (BT << slew) - 1) begin m_ref++; m_cnt = 0; end
            else m_cnt++;
          end
        end else m_cnt = 0;
        if (atsp) m_inh = 0;
      end
      m_tgt = sel ? c1 : c0;
      m_pwm = sel ? p1 : p0;
      m_en  = sel ? e1 : e0;
    end
    started = 1;
  end

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      chk(ref_code, m_ref, "R3/R4/R6/R9 ref_code");
      chk(pwm_o, m_pwm, "R2 force_pwm");
      chk(en_o, m_en, "R1 sw_en");
      chk(inh_o, m_inh, "R5 sw_inhibit");
      chk(done_o, (m_ref == m_tgt), "R7 ramp_done");
    end
    tick <= (cyc % tick_div == 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sp();
    @(negedge clk); atsp <= 1;
    @(negedge clk); atsp <= 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    idle(4);
    // R8 reset state
    chk(ref_code, RC, "R8 reset code");
    chk(done_o, 1, "R8 reset done");
    chk(inh_o, 0, "R8 reset inhibit");
    chk(en_o, 0, "R8 reset enable");
    chk(pwm_o, 0, "R8 reset pwm");
    rst <= 0;
    idle(3);
    // R1/R3 rise on set 0, fastest slew
    c0 <= 30; p0 <= 1; e0 <= 1; c1 <= 10; e1 <= 0; p1 <= 0;
    idle(40);
    chk(ref_code, 30, "R3 ramp reached set0");
    // R5 comparator pulse without inhibit has no effect
    pulse_sp();
    idle(2);
    chk(inh_o, 0, "R5 idle setpoint ignored");
    // R4/R5 select set 1 below -> jump
    sel <= 1;
    idle(3);
    chk(ref_code, 10, "R4 jump to set1");
    chk(inh_o, 1, "R5 inhibit raised");
    idle(10);
    chk(inh_o, 1, "R5 inhibit held");
    pulse_sp();
    idle(2);
    chk(inh_o, 0, "R5 inhibit cleared");
    // R3 slow tick, slew 3
    tick_div = 3; slew <= 3; c1 <= 14; p1 <= 1; e1 <= 1;
    idle(500);
    chk(ref_code, 14, "R3 slew3 slow tick");
    // R6 retarget mid-ramp up then down
    tick_div = 1; slew <= 1; c1 <= 40;
    idle(30);
    c1 <= 50;
    idle(30);
    c1 <= 18;
    idle(5);
    chk(ref_code, 18, "R6 retarget below");
    pulse_sp();
    // R3 slowest slew
    slew <= 7; c1 <= 21;
    idle(800);
    chk(ref_code, 21, "R3 slew7 reached");
    // R1 back to set 0 via select, with all slews briefly
    for (int s = 0; s < 8; s++) begin
      slew <= 3'(s); sel <= s[0]; c0 <= 6'(22 + s); c1 <= 6'(25 - s);
      idle(40);
    end
    c0 <= 63; sel <= 0; slew <= 0;
    idle(200);
    chk(ref_code, 63, "R9 top code");
    c0 <= 0;
    idle(4);
    chk(ref_code, 0, "R4 bottom code");
    // R8 reset mid-operation
    rst <= 1; idle(2);
    chk(ref_code, RC, "R8 reset again");
    rst <= 0; idle(5);
    finish_run();
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    finish_run();
  end
endmodule